// File: doc/BRIEF.md
# Per-Lane Bidirectional Variable Shifter

This block shifts every lane of a 128-bit data vector by an amount taken from the same lane of a second 128-bit vector. The amount is the low byte of that lane read as a two's-complement number: zero or positive values shift left, and negative values shift right by their magnitude. A two-bit size code sets the lane width to 8, 16, 32 or 64 bits. A signedness input selects between arithmetic and logical right shifts. It also sets how amounts that are too large for the lane are resolved.

The block is purely combinational and has no clock, reset or state. It builds all four lane widths in parallel, with one shifter unit per lane and per width. The size code then picks one of the four result vectors. Each lane unit resolves to one of four named operations: left shift, logical right shift, arithmetic right shift, or flush. A flush replaces the lane with all zeros or with a copy of its sign bit.

Top module: `bidir_lane_shifter`

## Requirements
- R1: The shift count of a lane is bits [7:0] of the matching shift lane, read as a signed value from -128 to 127. All higher bits of the shift lane have no effect.
- R2: A count of 0 or more shifts the data lane left. Bits leaving the top of the lane are lost and the vacated low bits become 0. A count of 0 returns the lane unchanged.
- R3: A negative count shifts right by its magnitude. The shift is arithmetic (sign bit copied in) when the signedness input is 1 and logical (zeros in) when it is 0.
- R4: With the signedness input at 0, a count whose magnitude is at least the lane width gives a lane of 0, for both left and right counts.
- R5: With the signedness input at 1, a left count of at least the lane width gives a lane of 0.
- R6: With the signedness input at 1, a right count whose magnitude is at least the lane width gives all ones (-1) when the data lane's top bit is 1, and 0 otherwise.
- R7: Size code 0, 1, 2 and 3 gives lanes of 8, 16, 32 and 64 bits, so 16, 8, 4 or 2 lanes. Lane i occupies bits [i*W +: W].
- R8: Lanes are independent. No bit of one lane's data or count reaches any other lane's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_a | input | 128 | Data vector to be shifted |
| vec_b | input | 128 | Shift vector; the low byte of each lane is that lane's count |
| size_code | input | 2 | Lane width select: 0=8, 1=16, 2=32, 3=64 bits |
| is_signed | input | 1 | 1 selects signed lanes, 0 selects unsigned lanes |
| vec_y | output | 128 | Shifted result vector |

## Verification
The hardest cases to reach are the boundaries between operations within one lane. These are counts of exactly W-1, W, -(W-1) and -W, and the extreme counts 127 and -128. At these values an off-by-one in the range compare, or a magnitude that overflows its width, changes the result. Random stimulus almost never lands on them. Directed tasks therefore place these counts in the low byte of every lane and set the higher bits of each shift lane to noise. They pair each count with positive and negative data, for both signedness settings and all four lane widths. A separate task puts a wide shift in one lane between zeroed neighbours, to show that no bits cross a lane boundary.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int VEC_W    = 128;
    localparam int CNT_W    = 8;
    localparam int MAG_W    = CNT_W + 1;
    localparam int N_SIZES  = 4;

    typedef enum logic [1:0] {
        LANE_SZ8  = 2'd0,
        LANE_SZ16 = 2'd1,
        LANE_SZ32 = 2'd2,
        LANE_SZ64 = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        OP_LEFT      = 2'd0,
        OP_RIGHT_LOG = 2'd1,
        OP_RIGHT_ARI = 2'd2,
        OP_FLUSH     = 2'd3
    } lane_op_e;

    function automatic int lane_width(input int sz);
        return 8 << sz;
    endfunction

endpackage

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
    import shift_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] data_i,
    input  logic [CNT_W-1:0]  amt_i,
    input  logic              signed_i,
    output logic [LANE_W-1:0] data_o
);

    localparam logic [MAG_W-1:0] WIDTH_LIM = MAG_W'(LANE_W);

    logic              is_right;
    logic [MAG_W-1:0]  mag;
    logic              beyond;
    lane_op_e          op_sel;
    logic [LANE_W-1:0] left_v;
    logic [LANE_W-1:0] right_log_v;
    logic [LANE_W-1:0] right_ari_v;
    logic [LANE_W-1:0] flush_v;

    // Decode the count into a direction and a magnitude of 0..128.
    always_comb begin
        is_right = amt_i[CNT_W-1];
        if (is_right) begin
            mag = MAG_W'(0) - {1'b1, amt_i};
        end else begin
            mag = {1'b0, amt_i};
        end
        beyond = (mag >= WIDTH_LIM);
    end

    // Pick which of the four lane operations applies.
    always_comb begin
        if (beyond) begin
            op_sel = OP_FLUSH;
        end else if (!is_right) begin
            op_sel = OP_LEFT;
        end else if (signed_i) begin
            op_sel = OP_RIGHT_ARI;
        end else begin
            op_sel = OP_RIGHT_LOG;
        end
    end

    // Candidate results.
    always_comb begin
        left_v      = data_i << mag;
        right_log_v = data_i >> mag;
        right_ari_v = LANE_W'($signed(data_i) >>> mag);
        // Flush: a signed right shift of a negative lane saturates to -1.
        flush_v     = {LANE_W{signed_i & is_right & data_i[LANE_W-1]}};
    end

    always_comb begin
        unique case (op_sel)
            OP_LEFT:      data_o = left_v;
            OP_RIGHT_LOG: data_o = right_log_v;
            OP_RIGHT_ARI: data_o = right_ari_v;
            OP_FLUSH:     data_o = flush_v;
            default:      data_o = '0;
        endcase
    end

endmodule

// File: rtl/lane_array.sv
module lane_array
    import shift_pkg::*;
#(
    parameter int ARR_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [ARR_W-1:0] data_i,
    input  logic [ARR_W-1:0] amt_i,
    input  logic             signed_i,
    output logic [ARR_W-1:0] data_o
);

    localparam int N_LANES = ARR_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] amt_lane;
        assign amt_lane = amt_i[i*LANE_W +: LANE_W];

        lane_shift_unit #(
            .LANE_W (LANE_W)
        ) u_unit (
            .data_i   (data_i[i*LANE_W +: LANE_W]),
            .amt_i    (amt_lane[CNT_W-1:0]),
            .signed_i (signed_i),
            .data_o   (data_o[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/bidir_lane_shifter.sv
module bidir_lane_shifter
    import shift_pkg::*;
(
    input  logic [127:0] vec_a,
    input  logic [127:0] vec_b,
    input  logic [1:0]   size_code,
    input  logic         is_signed,
    output logic [127:0] vec_y
);

    logic [VEC_W-1:0] per_size [N_SIZES];
    lane_size_e       size_sel;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        lane_array #(
            .ARR_W  (VEC_W),
            .LANE_W (lane_width(s))
        ) u_arr (
            .data_i   (vec_a),
            .amt_i    (vec_b),
            .signed_i (is_signed),
            .data_o   (per_size[s])
        );
    end

    assign size_sel = lane_size_e'(size_code);

    always_comb begin
        unique case (size_sel)
            LANE_SZ8:  vec_y = per_size[0];
            LANE_SZ16: vec_y = per_size[1];
            LANE_SZ32: vec_y = per_size[2];
            LANE_SZ64: vec_y = per_size[3];
            default:   vec_y = '0;
        endcase
    end

endmodule

// File: rtl/bidir_lane_shifter_checker.sv
module bidir_lane_shifter_checker (
    input logic [127:0] vec_a,
    input logic [127:0] vec_b,
    input logic [1:0]   size_code,
    input logic         is_signed,
    input logic [127:0] vec_y
);

    // Properties on lane 0 of the selected width, observed at the ports.
    int                 w;
    logic [63:0]        mask;
    logic [63:0]        a0;
    logic [63:0]        y0;
    logic signed [7:0]  cnt;
    int                 mag;

    always_comb begin
        w    = 8 << size_code;
        mask = (size_code == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        a0   = vec_a[63:0] & mask;
        y0   = vec_y[63:0] & mask;
        cnt  = vec_b[7:0];
        mag  = (cnt < 0) ? -int'(cnt) : int'(cnt);

        // R2: zero count leaves the lane unchanged
        if (cnt == 0) begin
            assert_zero_count_R2: assert (y0 == a0);
        end
        // R4: unsigned out-of-range count gives zero
        if (!is_signed && mag >= w) begin
            assert_unsigned_flush_R4: assert (y0 == 64'd0);
        end
        // R5: signed left out-of-range count gives zero
        if (is_signed && cnt >= 0 && int'(cnt) >= w) begin
            assert_signed_left_flush_R5: assert (y0 == 64'd0);
        end
        // R6: signed right out-of-range count gives the sign fill
        if (is_signed && cnt < 0 && mag >= w) begin
            assert_signed_right_flush_R6: assert (y0 == (a0[w-1] ? mask : 64'd0));
        end
        // R3: a signed right shift of a negative lane keeps the top bit set
        if (is_signed && cnt < 0 && a0[w-1]) begin
            assert_sign_kept_R3: assert (y0[w-1] == 1'b1);
        end
    end

endmodule

bind bidir_lane_shifter bidir_lane_shifter_checker u_chk (
    .vec_a     (vec_a),
    .vec_b     (vec_b),
    .size_code (size_code),
    .is_signed (is_signed),
    .vec_y     (vec_y)
);

// File: tb/bidir_lane_shifter_tb.sv
module bidir_lane_shifter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic [127:0] vec_a = '0;
    logic [127:0] vec_b = '0;
    logic [1:0]   size_code = 2'd0;
    logic         is_signed = 1'b0;
    logic [127:0] vec_y;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_lane_shifter u_dut (
        .vec_a     (vec_a),
        .vec_b     (vec_b),
        .size_code (size_code),
        .is_signed (is_signed),
        .vec_y     (vec_y)
    );

    // Reference for one lane, written from the requirements.
    function automatic logic [63:0] model_lane(input logic [63:0] a, input logic [7:0] b,
                                               input int w, input bit sgn);
        logic [63:0] m;
        logic [63:0] r;
        int          c;
        logic signed [63:0] sa;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        a = a & m;
        c = int'($signed(b));
        if (c >= 0) begin
            r = (c >= w) ? 64'd0 : ((a << c) & m);
        end else if (-c >= w) begin
            r = (sgn && a[w-1]) ? m : 64'd0;
        end else if (sgn) begin
            sa = $signed(a << (64 - w)) >>> (64 - w);
            r  = 64'(sa >>> (-c)) & m;
        end else begin
            r = a >> (-c);
        end
        return r;
    endfunction

    function automatic logic [127:0] model_vec(input logic [127:0] a, input logic [127:0] b,
                                               input logic [1:0] sz, input bit sgn);
        logic [127:0] r;
        logic [63:0]  l;
        int           w;
        r = '0;
        w = 8 << sz;
        for (int i = 0; i < 128 / w; i++) begin
            l = model_lane(64'(a >> (i*w)), b[i*w +: 8], w, sgn);
            for (int k = 0; k < w; k++) r[i*w + k] = l[k];
        end
        return r;
    endfunction

    task automatic apply_and_check(input logic [127:0] a, input logic [127:0] b,
                                   input logic [1:0] sz, input bit sgn, input string req);
        logic [127:0] exp;
        @(posedge clk);
        vec_a = a; vec_b = b; size_code = sz; is_signed = sgn;
        exp = model_vec(a, b, sz, sgn);
        @(negedge clk);
        n_checks++;
        if (vec_y !== exp) begin
            n_fail++;
            $display("FAIL %s size=%0d sgn=%0d a=%h b=%h actual=%h expected=%h",
                     req, sz, sgn, a, b, vec_y, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Fill every lane's low byte with cnt, upper bits with noise (R1).
    function automatic logic [127:0] spread_count(input logic [7:0] cnt, input logic [1:0] sz);
        logic [127:0] r;
        int w;
        r = rnd128();
        w = 8 << sz;
        for (int i = 0; i < 128 / w; i++) r[i*w +: 8] = cnt;
        return r;
    endfunction

    task automatic t_idle_zero();
        // R7: all-zero inputs give all-zero output at every size
        for (int s = 0; s < 4; s++) apply_and_check('0, '0, 2'(s), 1'b0, "R7");
    endtask

    task automatic t_low_byte_only();
        // R1: upper shift-lane bits are noise; only the low byte counts
        for (int s = 1; s < 4; s++) begin
            apply_and_check(rnd128(), spread_count(8'h03, 2'(s)), 2'(s), 1'b0, "R1");
            apply_and_check(rnd128(), spread_count(8'hFD, 2'(s)), 2'(s), 1'b1, "R1");
        end
    endtask

    task automatic t_left_shifts();
        // R2: left shifts including count 0, top bits discarded
        for (int s = 0; s < 4; s++) begin
            apply_and_check(rnd128(), spread_count(8'd0, 2'(s)), 2'(s), 1'b1, "R2");
            apply_and_check({16{8'hFF}}, spread_count(8'd1, 2'(s)), 2'(s), 1'b0, "R2");
            apply_and_check(rnd128(), spread_count(8'd5, 2'(s)), 2'(s), 1'b1, "R2");
        end
    endtask

    task automatic t_right_shifts();
        // R3: arithmetic vs logical right shifts on negative data
        for (int s = 0; s < 4; s++) begin
            apply_and_check({16{8'h80}}, spread_count(8'hFF, 2'(s)), 2'(s), 1'b1, "R3");
            apply_and_check({16{8'h80}}, spread_count(8'hFF, 2'(s)), 2'(s), 1'b0, "R3");
            apply_and_check(rnd128(), spread_count(8'hFA, 2'(s)), 2'(s), 1'b1, "R3");
        end
    endtask

    task automatic t_range_edges();
        logic [7:0] cs [8];
        for (int s = 0; s < 4; s++) begin
            int w;
            w = 8 << s;
            cs[0] = 8'(w - 1); cs[1] = 8'(w); cs[2] = 8'(-(w - 1)); cs[3] = 8'(-w);
            cs[4] = 8'd127;    cs[5] = 8'h80; cs[6] = 8'(w + 1);    cs[7] = 8'(-(w + 1));
            for (int k = 0; k < 8; k++) begin
                // R4: unsigned edges; R5/R6: signed edges, with negative and positive data
                apply_and_check(rnd128(), spread_count(cs[k], 2'(s)), 2'(s), 1'b0, "R4");
                apply_and_check({16{8'hC3}}, spread_count(cs[k], 2'(s)), 2'(s), 1'b1, "R6");
                apply_and_check({16{8'h3C}}, spread_count(cs[k], 2'(s)), 2'(s), 1'b1, "R5");
            end
        end
    endtask

    task automatic t_lane_isolation();
        // R8: one lane full of ones with extreme counts; neighbours zero
        for (int s = 0; s < 4; s++) begin
            int w;
            logic [127:0] a;
            logic [127:0] b;
            w = 8 << s;
            a = '0; b = '0;
            for (int k = 0; k < w; k++) a[w + k] = 1'b1;
            b[w +: 8] = 8'(w - 1);
            b[7:0]    = 8'h81;
            apply_and_check(a, b, 2'(s), 1'b1, "R8");
            b[w +: 8] = 8'(-(w - 1));
            apply_and_check(a, b, 2'(s), 1'b1, "R8");
        end
    endtask

    task automatic t_random();
        // R7: random data and counts across all sizes and signedness
        for (int n = 0; n < 400; n++) begin
            apply_and_check(rnd128(), rnd128(), 2'(n % 4), 1'((n / 4) % 2), "R7");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_idle_zero();
        t_low_byte_only();
        t_left_shifts();
        t_right_shifts();
        t_range_edges();
        t_lane_isolation();
        t_random();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule